// File: doc/BRIEF.md
# Segment Descriptor Cache Unit

This block models one segment register together with the hidden copy of its descriptor, a cached base and a cached limit. Loading a selector refreshes that hidden copy. The rule depends on the current mode. In real mode only the base changes, and it becomes the selector times sixteen. In protected mode both the base and the limit come from descriptor fields supplied by the caller. The limit can be scaled to 4 KiB units.

Each access request carries a 32-bit offset and a size code. One clock later the block returns one of two results. A request that stays inside the cached limit returns a valid linear address, which is the cached base plus the offset. A request that runs past the limit raises a limit fault instead.

Because a real-mode load never touches the limit, software can do a protected-mode load with a 4 GiB limit, return to real mode, and still use full 32-bit offsets there.

Top module: `seg_cache_unit`

## Requirements
- R1: After reset the cached base is 0 and the cached limit is 0xFFFF, so an access ending at offset 0xFFFF is accepted and one ending at 0x10000 faults.
- R2: A selector load with `prot_mode` low (real mode) sets the cached base to the 16-bit selector shifted left by 4 (zero-extended to 32 bits).
- R3: A selector load in real mode leaves the cached limit unchanged; only a load with `prot_mode` high may change it.
- R4: A selector load with `prot_mode` high sets the base to `desc_base`. It sets the limit to the 20-bit `desc_limit` when `desc_gran` is 0, or to `{desc_limit, 12'hFFF}` when `desc_gran` is 1.
- R5: A limit set by a protected-mode load remains in force after later real-mode loads.
- R6: The access size code maps to a byte count: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. An access faults when offset + bytes - 1, computed without wrapping, exceeds the cached limit. `addr_valid` and `limit_fault` are never high together.
- R7: For an accepted access, `lin_addr` equals the cached base plus the offset, modulo 2^32.
- R8: Results are registered and appear on the clock edge that follows `acc_req`. An access in the same cycle as a load uses the cache contents from before that load. A cycle without `acc_req` gives `addr_valid` and `limit_fault` low.
- R9: With a cached limit of 0xFFFFFFFF in real mode, a 1-byte access at offset 0xFFFFFFFF is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| sel_load | input | 1 | Selector-load strobe |
| sel_value | input | 16 | Selector being loaded |
| desc_base | input | 32 | Descriptor base for protected-mode loads |
| desc_limit | input | 20 | Descriptor raw limit for protected-mode loads |
| desc_gran | input | 1 | Limit scaled to 4 KiB units when 1 |
| acc_req | input | 1 | Access request |
| acc_offset | input | 32 | Access offset |
| acc_size | input | 2 | Access size code (see R6) |
| lin_addr | output | 32 | Linear address of the last request |
| addr_valid | output | 1 | Last request accepted |
| limit_fault | output | 1 | Last request exceeded the limit |

## Verification
Accesses are tried against the reset limit and against a byte-granular limit. They are also tried against a page-scaled limit, both small and full 4 GiB. Offsets sit one byte inside and one byte past each limit, which separates an off-by-one in the end-of-access sum from a correct compare. Real-mode reloads made after a protected-mode load show whether the limit survives or is wrongly rewritten. Base-plus-offset pairs that carry past bit 31 show whether the address wraps. A load issued in the same cycle as an access shows which cache contents the access saw. A long stretch of random loads, mode changes and near-limit offsets is then checked against the reference model on every clock.

// File: rtl/segcache_pkg.sv
package segcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int SEL_W      = 16;
    localparam int DLIM_W     = 20;
    localparam int GRAN_SHIFT = ADDR_W - DLIM_W;
    localparam int SIZE_W     = 2;
    localparam int REAL_SHIFT = 4;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } seg_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } seg_cache_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fault;
    } acc_result_t;

    // Last byte touched by an access, one bit wider so it never wraps.
    function automatic logic [ADDR_W:0] access_end(input logic [ADDR_W-1:0] ofs,
                                                   input logic [SIZE_W-1:0] size_code);
        logic [ADDR_W:0] extra;
        extra = '0;
        extra[(1<<SIZE_W)-1:0] = ((1<<SIZE_W)'(1) << size_code) - (1<<SIZE_W)'(1);
        return {1'b0, ofs} + extra;
    endfunction

    // Byte or page-scaled limit from the raw descriptor field.
    function automatic logic [ADDR_W-1:0] scale_limit(input logic [DLIM_W-1:0] raw,
                                                      input logic gran);
        if (gran)
            return {raw, {GRAN_SHIFT{1'b1}}};
        else
            return {{GRAN_SHIFT{1'b0}}, raw};
    endfunction

    function automatic logic [ADDR_W-1:0] real_base(input logic [SEL_W-1:0] sel);
        return {{(ADDR_W-SEL_W-REAL_SHIFT){1'b0}}, sel, {REAL_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/seg_desc_regs.sv
module seg_desc_regs
    import segcache_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_BASE  = '0,
    parameter logic [ADDR_W-1:0] RESET_LIMIT = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  seg_mode_e         mode,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] dbase,
    input  logic [DLIM_W-1:0] dlimit,
    input  logic              dgran,
    output seg_cache_t        cache
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cache.base  <= RESET_BASE;
            cache.limit <= RESET_LIMIT;
        end else if (load) begin
            if (mode == MODE_PROT) begin
                cache.base  <= dbase;
                cache.limit <= scale_limit(dlimit, dgran);
            end else begin
                cache.base  <= real_base(sel);
            end
        end
    end

    AST_REAL_BASE: assert property (@(posedge clk) disable iff (rst)
        (load && mode == MODE_REAL) |=> cache.base[REAL_SHIFT-1:0] == '0 &&
            cache.base[REAL_SHIFT +: SEL_W] == $past(sel)); // R2

    AST_REAL_KEEPS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (load && mode == MODE_REAL) |=> $stable(cache.limit)); // R3

    AST_LIMIT_ONLY_PROT: assert property (@(posedge clk) disable iff (rst)
        !(load && mode == MODE_PROT) |=> $stable(cache.limit)); // R5

    AST_PROT_BASE: assert property (@(posedge clk) disable iff (rst)
        (load && mode == MODE_PROT) |=> cache.base == $past(dbase)); // R4

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import segcache_pkg::*;
(
    input  logic [ADDR_W-1:0] ofs,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] limit,
    output logic              over
);

    logic [ADDR_W:0] last_byte;

    always_comb begin
        last_byte = access_end(ofs, size_code);
        over      = last_byte > {1'b0, limit};
    end

    AST_FULL_LIMIT_SINGLE_OK: assert final
        (!(limit == '1 && size_code == '0) || !over); // R9

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segcache_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    output logic [ADDR_W-1:0] addr
);

    always_comb addr = base + ofs;

endmodule

// File: rtl/seg_cache_unit.sv
module seg_cache_unit
    import segcache_pkg::*;
#(
    parameter logic [31:0] RESET_BASE  = 32'h0000_0000,
    parameter logic [31:0] RESET_LIMIT = 32'h0000_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        prot_mode,
    input  logic        sel_load,
    input  logic [15:0] sel_value,
    input  logic [31:0] desc_base,
    input  logic [19:0] desc_limit,
    input  logic        desc_gran,
    input  logic        acc_req,
    input  logic [31:0] acc_offset,
    input  logic [1:0]  acc_size,
    output logic [31:0] lin_addr,
    output logic        addr_valid,
    output logic        limit_fault
);

    seg_cache_t  cache;
    acc_result_t res;
    seg_mode_e   mode;

    assign mode = seg_mode_e'(prot_mode);

    seg_desc_regs #(
        .RESET_BASE  (RESET_BASE),
        .RESET_LIMIT (RESET_LIMIT)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .load   (sel_load),
        .sel    (sel_value),
        .dbase  (desc_base),
        .dlimit (desc_limit),
        .dgran  (desc_gran),
        .cache  (cache)
    );

    seg_addr_gen u_addr (
        .base (cache.base),
        .ofs  (acc_offset),
        .addr (res.addr)
    );

    seg_limit_check u_lim (
        .ofs       (acc_offset),
        .size_code (acc_size),
        .limit     (cache.limit),
        .over      (res.fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_addr    <= '0;
            addr_valid  <= 1'b0;
            limit_fault <= 1'b0;
        end else begin
            lin_addr    <= res.addr;
            addr_valid  <= acc_req && !res.fault;
            limit_fault <= acc_req && res.fault;
        end
    end

    AST_FAULT_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (rst)
        !(addr_valid && limit_fault)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> !addr_valid && !limit_fault); // R8

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> (addr_valid || limit_fault)); // R8

    AST_FULL_LIMIT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (acc_req && cache.limit == '1 && acc_size == 2'd0) |=> addr_valid); // R9

    AST_ADDR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> lin_addr == $past(cache.base) + $past(acc_offset)); // R7

endmodule

// File: tb/seg_cache_unit_bench.sv
`timescale 1ns/1ps
module seg_cache_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_mode = 1'b0;
    logic        sel_load = 1'b0;
    logic [15:0] sel_value = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        acc_req = 1'b0;
    logic [31:0] acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] lin_addr;
    logic        addr_valid;
    logic        limit_fault;

    int n_cmp = 0;
    int n_bad = 0;

    longint unsigned m_base;
    longint unsigned m_limit;

    always #2 clk = ~clk;

    seg_cache_unit u_seg_cache_unit (
        .clk         (clk),
        .rst         (rst),
        .prot_mode   (prot_mode),
        .sel_load    (sel_load),
        .sel_value   (sel_value),
        .desc_base   (desc_base),
        .desc_limit  (desc_limit),
        .desc_gran   (desc_gran),
        .acc_req     (acc_req),
        .acc_offset  (acc_offset),
        .acc_size    (acc_size),
        .lin_addr    (lin_addr),
        .addr_valid  (addr_valid),
        .limit_fault (limit_fault)
    );

    task automatic compare(input string tag, input bit ev, input bit ef,
                           input longint unsigned ea);
        n_cmp++;
        if (addr_valid !== ev || limit_fault !== ef ||
            (ev && lin_addr !== ea[31:0])) begin
            n_bad++;
            $display("FAIL %s: valid/fault/addr = %0b/%0b/%h, expected %0b/%0b/%h",
                     tag, addr_valid, limit_fault, lin_addr, ev, ef, ea[31:0]);
        end
    endtask

    // One clock: drive at negedge, predict from model, compare at next negedge.
    task automatic step(input string tag, input bit pm, input bit ld,
                        input logic [15:0] sel, input logic [31:0] db,
                        input logic [19:0] dl, input bit g, input bit rq,
                        input logic [31:0] ofs, input logic [1:0] sz);
        longint unsigned last_b, ea;
        bit ev, ef;
        prot_mode = pm; sel_load = ld; sel_value = sel; desc_base = db;
        desc_limit = dl; desc_gran = g; acc_req = rq; acc_offset = ofs; acc_size = sz;
        last_b = longint'(ofs) + (longint'(1) << sz) - 1;
        ef = rq && (last_b > m_limit);
        ev = rq && !ef;
        ea = (m_base + longint'(ofs)) % (longint'(1) << 32);
        if (ld) begin
            if (pm) begin
                m_base  = longint'(db);
                m_limit = g ? (longint'(dl) * 4096 + 4095) : longint'(dl);
            end else begin
                m_base  = longint'(sel) * 16;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag, ev, ef, ea);
    endtask

    task automatic acc(input string tag, input bit pm, input logic [31:0] ofs,
                       input logic [1:0] sz);
        step(tag, pm, 1'b0, '0, '0, '0, 1'b0, 1'b1, ofs, sz);
    endtask

    task automatic rload(input string tag, input logic [15:0] sel);
        step(tag, 1'b0, 1'b1, sel, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic pload(input string tag, input logic [31:0] db,
                         input logic [19:0] dl, input bit g);
        step(tag, 1'b1, 1'b1, '0, db, dl, g, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_base = 0;
        m_limit = 64'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1 reset outputs", 1'b0, 1'b0, 0);

        acc("R1 reset limit edge", 1'b0, 32'h0000_FFFF, 2'd0);
        acc("R1 reset limit past", 1'b0, 32'h0001_0000, 2'd0);
        acc("R6 word straddles reset limit", 1'b0, 32'h0000_FFFF, 2'd1);

        rload("R2 real load", 16'h1234);
        acc("R2 base is selector*16", 1'b0, 32'h0000_0010, 2'd0);
        acc("R3 limit kept inside", 1'b0, 32'h0000_FFFE, 2'd1);
        acc("R3 limit kept past", 1'b0, 32'h0000_FFFF, 2'd1);

        pload("R4 byte-granular load", 32'h0010_0000, 20'h00FFF, 1'b0);
        acc("R4 dword at limit", 1'b1, 32'h0000_0FFC, 2'd2);
        acc("R6 dword one past", 1'b1, 32'h0000_0FFD, 2'd2);
        acc("R6 qword fits", 1'b1, 32'h0000_0FF8, 2'd3);
        acc("R6 qword one past", 1'b1, 32'h0000_0FF9, 2'd3);

        pload("R4 page-granular full", 32'h0000_0000, 20'hFFFFF, 1'b1);
        rload("R5 back to real", 16'h0010);
        acc("R5 big offset in real mode", 1'b0, 32'h1234_5678, 2'd2);
        acc("R9 full offset accepted", 1'b0, 32'hFFFF_FFFF, 2'd0);
        acc("R6 end past 4 GiB", 1'b0, 32'hFFFF_FFFD, 2'd2);

        step("R8 load with access uses old base", 1'b0, 1'b1, 16'h2000, '0, '0,
             1'b0, 1'b1, 32'h0000_0004, 2'd0);
        acc("R8 next access uses new base", 1'b0, 32'h0000_0004, 2'd0);

        pload("R4 small page limit", 32'hFFFF_F000, 20'h00001, 1'b1);
        acc("R7 wrap to zero", 1'b1, 32'h0000_1000, 2'd0);
        acc("R4 page limit edge", 1'b1, 32'h0000_1FFF, 2'd0);
        acc("R4 page limit past", 1'b1, 32'h0000_2000, 2'd0);

        for (int i = 0; i < 4; i++)
            step("R8 idle", 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'd3);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] o;
            bit pm;
            pm = 1'($urandom);
            case ($urandom % 3)
                0: o = $urandom;
                1: o = 32'(m_limit) - 32'($urandom % 8);
                default: o = 32'(m_limit) + 32'($urandom % 3);
            endcase
            step("R6 R7 random", pm, ($urandom % 6) == 0, 16'($urandom), $urandom,
                 20'($urandom), 1'($urandom), ($urandom % 4) != 0, o, 2'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule